// File: doc/BRIEF.md
# Spanning Tree Port State Table

This block keeps one entry per spanning-tree instance. Each entry holds a 2-bit forwarding state for every switch port and a valid flag. The table holds 64 instances, and a 6-bit instance number selects the entry. Software reaches the table through a small register window. The window has an instance-number register and a valid-flag register that the VLAN unit also uses. It also has the data registers the VLAN unit uses, where each port owns a 4-bit nibble. The lower two bits of a nibble carry VLAN membership, which this block does not store. The upper two bits carry the port's tree state.

A command register with a busy flag starts two operations. Load/purge writes or removes the entry named by the instance register. Get-next searches for the next valid instance above the one in the instance register, and copies its number and port states back into the window. Software can walk the whole table by issuing get-next again and again without reloading the instance number. Writing the all-ones instance number starts the walk from the bottom of the table.

Top module: `stp_state_table`

## Requirements
- R1: After reset the busy flag, the instance register, the valid flag and all data registers read 0, and the table holds no valid entry.
- R2: The instance register is at address 1 and keeps only bits [5:0]; its upper bits read 0. The valid-flag register is at address 2 and keeps only bit 12; all its other bits read 0. Data register k is at address 3+k.
- R3: A write to the command register (address 0) with bit 15 set, while busy reads 0, sets busy for exactly one cycle. The opcode is taken from bits [14:12], and it reads back in those bits with busy in bit 15. All results of the command are readable once busy reads 0 again.
- R4: While busy reads 1, writes to any register, including a second command, are ignored.
- R5: Load/purge (opcode 3) with the valid flag set stores, for port p, the 2 bits at data register p/4, bit offset (p%4)*4+2, into the entry selected by the instance register. Membership bits, and state bits beyond the last port, are not stored. Load/purge leaves the window registers unchanged.
- R6: Load/purge with the valid flag clear removes the selected entry, so that get-next skips it.
- R7: Get-next (opcode 4) finds the lowest valid instance strictly above the instance register. On a hit it writes that instance into the instance register, sets the valid flag, and loads each port state into its position of R5, with every other data register bit cleared to 0.
- R8: Repeated get-next without rewriting the instance register walks the valid entries in ascending order. When no valid entry lies above, it clears the valid flag and leaves the instance register and data registers unchanged.
- R9: Get-next from instance 63 (all ones) returns the lowest valid instance in the whole table, including 0.
- R10: A command write with bit 15 clear starts nothing. A command with an opcode other than 3 or 4 pulses busy but changes neither the table nor the window registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |

## Verification
A register write becomes readable on the first sample after the clock edge that captures it. Busy reads 1 on the sample just after the command write. The table update, or the search result, lands on the following edge, so it is readable one sample later. The bench drives and samples on the falling edge, always polls busy until it reads 0, and only then reads the valid flag, instance and data registers. The write-during-busy case is driven in exactly the one cycle that busy is high.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int OPC_W   = 3;
  localparam int GO_BIT  = 15;
  localparam int OPC_LSB = 12;
  localparam int VLD_BIT = 12;

  localparam logic [ADDR_W-1:0] ADDR_CMD = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SID = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_VLD = 3'd2;
  localparam int                ADDR_DATA0 = 3;

  localparam logic [OPC_W-1:0] OPC_LOAD = 3'd3;
  localparam logic [OPC_W-1:0] OPC_NEXT = 3'd4;

  // nibble layout shared with the VLAN unit: state lives in the top two bits
  localparam int PORTS_PER_REG = 4;
  localparam int NIBBLE_W      = 4;
  localparam int STATE_OFS     = 2;
endpackage

// File: rtl/stp_state_store.sv
module stp_state_store #(
  parameter int SID_W  = 6,
  parameter int NPORTS = 11,
  localparam int NSID = 1 << SID_W,
  localparam int ST_W = 2 * NPORTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SID_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [ST_W-1:0]  wr_states_i,
  input  logic [SID_W-1:0] rd_idx_i,
  output logic [ST_W-1:0]  rd_states_o,
  output logic [NSID-1:0]  valid_o
);
  logic [ST_W-1:0] mem_q [NSID];
  logic [NSID-1:0] valid_q;

  // only the valid vector is reset; states are read only for valid entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_valid_i ? wr_states_i : '0;
  end

  assign rd_states_o = mem_q[rd_idx_i];
  assign valid_o     = valid_q;
endmodule

// File: rtl/stp_next_finder.sv
module stp_next_finder #(
  parameter int SID_W = 6,
  localparam int NSID = 1 << SID_W
) (
  input  logic [NSID-1:0]  valid_i,
  input  logic [SID_W-1:0] start_i,
  output logic             hit_o,
  output logic [SID_W-1:0] idx_o
);
  logic            wrap;
  logic [NSID-1:0] cand;

  assign wrap = &start_i;

  for (genvar g = 0; g < NSID; g++) begin : g_cand
    assign cand[g] = valid_i[g] && (wrap || (g > int'(start_i)));
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NSID - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_o = 1'b1;
        idx_o = SID_W'(i);
      end
    end
  end
endmodule

// File: rtl/stp_lane_codec.sv
module stp_lane_codec
  import stp_pkg::*;
#(
  parameter int NPORTS = 11,
  localparam int NDATA = (NPORTS + PORTS_PER_REG - 1) / PORTS_PER_REG,
  localparam int DW    = NDATA * REG_W,
  localparam int ST_W  = 2 * NPORTS
) (
  input  logic [DW-1:0]   data_i,
  output logic [ST_W-1:0] states_o,
  input  logic [ST_W-1:0] states_i,
  output logic [DW-1:0]   data_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam int POS = (p / PORTS_PER_REG) * REG_W
                       + (p % PORTS_PER_REG) * NIBBLE_W + STATE_OFS;
    assign states_o[2*p +: 2] = data_i[POS +: 2];
  end

  always_comb begin
    data_o = '0;
    for (int p = 0; p < NPORTS; p++) begin
      data_o[(p / PORTS_PER_REG) * REG_W + (p % PORTS_PER_REG) * NIBBLE_W
             + STATE_OFS +: 2] = states_i[2*p +: 2];
    end
  end
endmodule

// File: rtl/stp_state_table.sv
module stp_state_table
  import stp_pkg::*;
#(
  parameter int SID_W  = 6,
  parameter int NPORTS = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  localparam int NSID  = 1 << SID_W;
  localparam int NDATA = (NPORTS + PORTS_PER_REG - 1) / PORTS_PER_REG;
  localparam int DW    = NDATA * REG_W;
  localparam int ST_W  = 2 * NPORTS;

  logic             busy_q;
  logic [OPC_W-1:0] opc_q;
  logic [SID_W-1:0] sid_q;
  logic             vld_q;
  logic [DW-1:0]    data_q;

  logic [NSID-1:0]  valid_vec;
  logic             hit;
  logic [SID_W-1:0] hit_idx;
  logic [ST_W-1:0]  rd_states;
  logic [ST_W-1:0]  wr_states;
  logic [DW-1:0]    found_data;
  logic             exec_load;
  logic             exec_next;

  assign exec_load = busy_q && (opc_q == OPC_LOAD);
  assign exec_next = busy_q && (opc_q == OPC_NEXT);

  stp_state_store #(.SID_W(SID_W), .NPORTS(NPORTS)) store_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (exec_load),
    .wr_idx_i    (sid_q),
    .wr_valid_i  (vld_q),
    .wr_states_i (wr_states),
    .rd_idx_i    (hit_idx),
    .rd_states_o (rd_states),
    .valid_o     (valid_vec)
  );

  stp_next_finder #(.SID_W(SID_W)) finder_i (
    .valid_i (valid_vec),
    .start_i (sid_q),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  stp_lane_codec #(.NPORTS(NPORTS)) codec_i (
    .data_i   (data_q),
    .states_o (wr_states),
    .states_i (rd_states),
    .data_o   (found_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      opc_q  <= '0;
      sid_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
      if (exec_next) begin
        if (hit) begin
          sid_q  <= hit_idx;
          vld_q  <= 1'b1;
          data_q <= found_data;
        end else begin
          vld_q <= 1'b0;
        end
      end
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_CMD) begin
        if (reg_wdata_i[GO_BIT]) begin
          busy_q <= 1'b1;
          opc_q  <= reg_wdata_i[OPC_LSB +: OPC_W];
        end
      end else if (reg_addr_i == ADDR_SID) begin
        sid_q <= reg_wdata_i[SID_W-1:0];
      end else if (reg_addr_i == ADDR_VLD) begin
        vld_q <= reg_wdata_i[VLD_BIT];
      end else begin
        for (int k = 0; k < NDATA; k++) begin
          if (int'(reg_addr_i) == ADDR_DATA0 + k) data_q[k*REG_W +: REG_W] <= reg_wdata_i;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CMD) begin
      reg_rdata_o[GO_BIT]            = busy_q;
      reg_rdata_o[OPC_LSB +: OPC_W]  = opc_q;
    end else if (reg_addr_i == ADDR_SID) begin
      reg_rdata_o[SID_W-1:0] = sid_q;
    end else if (reg_addr_i == ADDR_VLD) begin
      reg_rdata_o[VLD_BIT] = vld_q;
    end else begin
      for (int k = 0; k < NDATA; k++) begin
        if (int'(reg_addr_i) == ADDR_DATA0 + k) reg_rdata_o = data_q[k*REG_W +: REG_W];
      end
    end
  end
endmodule

// File: rtl/stp_state_table_chk.sv
module stp_state_table_chk
  import stp_pkg::*;
#(
  parameter int SID_W  = 6,
  parameter int NPORTS = 11,
  localparam int NDATA = (NPORTS + PORTS_PER_REG - 1) / PORTS_PER_REG,
  localparam int DW    = NDATA * REG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_wr_i,
  input logic             go_bit_i,
  input logic             busy_i,
  input logic [OPC_W-1:0] opc_i,
  input logic [SID_W-1:0] sid_i,
  input logic             vld_i,
  input logic [DW-1:0]    data_i
);
  function automatic logic [DW-1:0] state_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int p = 0; p < NPORTS; p++) begin
      m[(p / PORTS_PER_REG) * REG_W + (p % PORTS_PER_REG) * NIBBLE_W + STATE_OFS +: 2] = 2'b11;
    end
    return m;
  endfunction

  localparam logic [DW-1:0] SMASK = state_mask();

  p_busy_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !busy_i);

  p_cmd_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && go_bit_i) |=> busy_i);

  p_no_go_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && cmd_wr_i && !go_bit_i) |=> !busy_i);

  p_sid_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && opc_i != OPC_NEXT) |=> $stable(sid_i));

  p_data_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && opc_i != OPC_NEXT) |=> ($stable(data_i) && $stable(vld_i)));

  p_next_higher_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && opc_i == OPC_NEXT && !(&sid_i)) |=> (!vld_i || sid_i > $past(sid_i)));

  p_member_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && opc_i == OPC_NEXT) |=> (!vld_i || (data_i & ~SMASK) == '0));

  p_miss_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && opc_i == OPC_NEXT) |=> (vld_i || ($stable(sid_i) && $stable(data_i))));
endmodule

bind stp_state_table stp_state_table_chk #(.SID_W(SID_W), .NPORTS(NPORTS)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_wr_i (reg_we_i && (reg_addr_i == stp_pkg::ADDR_CMD)),
  .go_bit_i (reg_wdata_i[stp_pkg::GO_BIT]),
  .busy_i   (busy_q),
  .opc_i    (opc_q),
  .sid_i    (sid_q),
  .vld_i    (vld_q),
  .data_i   (data_q)
);

// File: tb/stp_state_table_tb.sv
module stp_state_table_tb_top;
  localparam logic [2:0] A_CMD = 3'd0, A_SID = 3'd1, A_VLD = 3'd2, A_D0 = 3'd3;
  localparam logic [15:0] CMD_LOAD = 16'hB000;  // go + opcode 3
  localparam logic [15:0] CMD_NEXT = 16'hC000;  // go + opcode 4

  typedef struct packed {
    logic        nxt;
    logic        wsid;
    logic [7:0]  sid;
    logic        vld;
    logic [15:0] d0, d1, d2;
    logic [3:0]  req;
    logic        ev;
    logic [5:0]  es;
    logic [15:0] e0, e1, e2;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 8'h05, 1'b1, 16'hFFFF, 16'h0000, 16'hFFFF, 4'd5, 1'b1, 6'h05, 16'hFFFF, 16'h0000, 16'hFFFF}, // R5
    '{1'b0, 1'b1, 8'h14, 1'b1, 16'hD095, 16'h0C48, 16'hC804, 4'd5, 1'b1, 6'h14, 16'hD095, 16'h0C48, 16'hC804}, // R5
    '{1'b0, 1'b1, 8'h3F, 1'b1, 16'h0004, 16'h0000, 16'h0800, 4'd5, 1'b1, 6'h3F, 16'h0004, 16'h0000, 16'h0800}, // R5
    '{1'b0, 1'b1, 8'h00, 1'b1, 16'h0008, 16'h4000, 16'h0000, 4'd5, 1'b1, 6'h00, 16'h0008, 16'h4000, 16'h0000}, // R5
    '{1'b0, 1'b1, 8'h05, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd6, 1'b0, 6'h05, 16'h0000, 16'h0000, 16'h0000}, // R6 purge
    '{1'b1, 1'b1, 8'h3F, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd9, 1'b1, 6'h00, 16'h0008, 16'h4000, 16'h0000}, // R9 wrap
    '{1'b1, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd7, 1'b1, 6'h14, 16'hC084, 16'h0C48, 16'h0804}, // R7 skips purged 5
    '{1'b1, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd8, 1'b1, 6'h3F, 16'h0004, 16'h0000, 16'h0800}, // R8 walk
    '{1'b0, 1'b1, 8'h3F, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd6, 1'b0, 6'h3F, 16'h0000, 16'h0000, 16'h0000}, // R6
    '{1'b1, 1'b1, 8'h14, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd8, 1'b0, 6'h14, 16'h0000, 16'h0000, 16'h0000}, // R8 miss
    '{1'b1, 1'b1, 8'h03, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd7, 1'b1, 6'h14, 16'hC084, 16'h0C48, 16'h0804}, // R7
    '{1'b0, 1'b1, 8'h4A, 1'b1, 16'h000C, 16'h0000, 16'h0000, 4'd2, 1'b1, 6'h0A, 16'h000C, 16'h0000, 16'h0000}, // R2 mask
    '{1'b1, 1'b1, 8'h03, 1'b0, 16'h0000, 16'h0000, 16'h0000, 4'd7, 1'b1, 6'h0A, 16'h000C, 16'h0000, 16'h0000}  // R7
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  stp_state_table dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o)
  );

  always #4ns clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1ns;
    d = reg_rdata_o;
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    logic [15:0] r;
    reg_rd(A_CMD, r);
    while (r[15]) reg_rd(A_CMD, r);
  endtask

  task automatic check_window(input string req, input logic ev, input logic [5:0] es,
                              input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2);
    logic [15:0] r;
    reg_rd(A_VLD, r);    check({req, " valid"}, r, {3'b000, ev, 12'h000});
    reg_rd(A_SID, r);    check({req, " sid"},   r, {10'd0, es});
    reg_rd(A_D0, r);     check({req, " data0"}, r, e0);
    reg_rd(A_D0 + 3'd1, r); check({req, " data1"}, r, e1);
    reg_rd(A_D0 + 3'd2, r); check({req, " data2"}, r, e2);
  endtask

  task automatic run_vec(input vec_t v);
    if (v.wsid) reg_wr(A_SID, {8'h00, v.sid});
    if (!v.nxt) begin
      reg_wr(A_VLD, {3'b000, v.vld, 12'h000});
      reg_wr(A_D0, v.d0);
      reg_wr(A_D0 + 3'd1, v.d1);
      reg_wr(A_D0 + 3'd2, v.d2);
      reg_wr(A_CMD, CMD_LOAD);
    end else begin
      reg_wr(A_CMD, CMD_NEXT);
    end
    wait_idle();
    check_window($sformatf("R%0d vec", v.req), v.ev, v.es, v.e0, v.e1, v.e2);
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    reg_rd(A_CMD, r); check("R1 busy", r, 16'h0000);
    check_window("R1", 1'b0, 6'h00, 16'h0000, 16'h0000, 16'h0000);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R3 busy lasts one cycle, opcode reads back
    reg_wr(A_CMD, CMD_LOAD);
    reg_rd(A_CMD, r); check("R3 busy high", r, 16'hB000);
    reg_rd(A_CMD, r); check("R3 busy low", r, 16'h3000);

    // R4 write inside the busy cycle is dropped
    reg_wr(A_CMD, CMD_LOAD);
    reg_wr(A_SID, 16'h0021);
    reg_rd(A_SID, r); check("R4 sid kept", r, 16'h000A);
    reg_wr(A_CMD, CMD_NEXT);
    reg_wr(A_CMD, CMD_NEXT);  // second command during busy
    reg_rd(A_CMD, r); check("R4 second cmd dropped", r, 16'h4000);

    // R10 no go bit, then unknown opcode
    reg_wr(A_SID, 16'h0003);
    reg_wr(A_CMD, 16'h4000);
    reg_rd(A_CMD, r); check("R10 no go", r, 16'h4000);
    reg_wr(A_CMD, 16'hF000);
    reg_rd(A_CMD, r); check("R10 unknown busy", r, 16'hF000);
    wait_idle();
    reg_rd(A_SID, r); check("R10 sid untouched", r, 16'h0003);
    reg_wr(A_CMD, CMD_NEXT);
    wait_idle();
    check_window("R10 table intact", 1'b1, 6'h0A, 16'h000C, 16'h0000, 16'h0000);

    // R2 field masking
    reg_wr(A_VLD, 16'hFFFF);
    reg_rd(A_VLD, r); check("R2 valid reg", r, 16'h1000);
    reg_wr(A_SID, 16'hFFFF);
    reg_rd(A_SID, r); check("R2 sid reg", r, 16'h003F);

    // R1 reset mid-run clears table
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_window("R1 after reset", 1'b0, 6'h00, 16'h0000, 16'h0000, 16'h0000);
    reg_wr(A_SID, 16'h003F);
    reg_wr(A_CMD, CMD_NEXT);
    wait_idle();
    reg_rd(A_VLD, r); check("R1 table empty", r, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule